// File: doc/BRIEF.md
# Byte-Serial Column Mixer with Round-Key Addition

This stage sits behind the substitution box of a byte-wide block cipher datapath. In a regular round it takes one substituted state byte per cycle. Over four cycles it builds one mixed column in four byte accumulators, adds a 32-bit round-key word to all four bytes at once, and presents the word for a single write-back into the state storage. The result leaves with no extra pipeline stage.

Two round types bypass the mixing network. In the opening round, each incoming plaintext byte is combined with its key byte. Three holding bytes collect the first three results, so the fourth arrival releases a whole word, just as a regular round does. In the closing round, each byte is combined with one round-key byte and sent out at once as a ciphertext byte, in the order it arrived.

Top module: `mixcol_keyadd_stage`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `word_valid` and `ct_valid` are 0 and `word_out` and `ct_byte` are zero.
- R2: A byte accepted with `word_start` high is column position 0. Each later accepted byte takes the next position. After position 3 the next byte is position 0 even without `word_start`.
- R3: In a regular round, with column bytes a0..a3 at positions 0..3, output byte r (placed at `word_out[8r+7:8r]`) is the GF(2^8) sum of 2·a(r), 3·a(r+1), a(r+2) and a(r+3), with indices taken mod 4. The field polynomial is 0x11B.
- R4: In a regular round, the mixed word is XORed with the `rk_word` value present on the cycle of the position-3 byte.
- R5: `word_valid` is high for exactly the one cycle after the position-3 byte is accepted. `word_out` keeps its value until the next such pulse.
- R6: In the opening round, byte k of the released word (at `word_out[8k+7:8k]`) is `in_byte ^ key_byte` of position k. `rk_word` has no effect in this round.
- R7: In the closing round, each accepted byte produces `ct_byte = in_byte ^ key_byte` with a one-cycle `ct_valid` pulse on the next cycle, in arrival order. No `word_valid` pulse is produced in this round.
- R8: Cycles with `in_valid` low between the bytes of a column leave the column result unchanged.
- R9: `word_start` in the middle of a column discards the partial column. Only the new column produces a word.
- R10: A byte presented with none of `rnd_init`, `rnd_mid`, `rnd_last` set is ignored. It produces no pulse and takes no column position.
- R11: The first byte of a new column may arrive in the same cycle that the previous column's word is presented. Both columns are then computed correctly.
- R12: When several round flags are set together, `rnd_init` wins over `rnd_mid`, and `rnd_mid` wins over `rnd_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present on `in_byte` |
| in_byte | input | 8 | Substituted byte, or plaintext byte in the opening round |
| word_start | input | 1 | Marks the byte as column position 0 |
| key_byte | input | 8 | Key byte for the opening and closing rounds |
| rk_word | input | 32 | Round-key word for regular rounds |
| rnd_init | input | 1 | Opening round |
| rnd_mid | input | 1 | Regular round |
| rnd_last | input | 1 | Closing round |
| word_out | output | 32 | Word for write-back, byte r at bits 8r+7:8r |
| word_valid | output | 1 | One-cycle pulse: `word_out` is new |
| ct_byte | output | 8 | Ciphertext byte |
| ct_valid | output | 1 | One-cycle pulse: `ct_byte` is new |

## Verification
Two events can fall in the same cycle: the release of a finished word and the clearing of the accumulators for the first byte of the next column. The bench provokes this by sending columns with no idle cycle between them. It then compares each released word against a separately computed column mix of random bytes. A regular column that follows an opening column without a gap also tests the handover between the holding bytes and the accumulators.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
  localparam int BYTE_W = 8;
  localparam int COL_N  = 4;
  localparam int WORD_W = BYTE_W * COL_N;
  localparam int POS_W  = $clog2(COL_N);
  localparam logic [BYTE_W-1:0] GF_POLY = 8'h1B;

  function automatic logic [BYTE_W-1:0] gf_dbl(input logic [BYTE_W-1:0] b);
    gf_dbl = {b[BYTE_W-2:0], 1'b0} ^ (b[BYTE_W-1] ? GF_POLY : '0);
  endfunction

  // coefficient applied to a byte at position pos for output row row: 1, 2 or 3
  function automatic logic [BYTE_W-1:0] gf_term(input logic [BYTE_W-1:0] b,
                                                input logic [POS_W-1:0] pos,
                                                input int row);
    logic [POS_W-1:0] d;
    d = pos - POS_W'(row);
    case (d)
      2'd0:    gf_term = gf_dbl(b);
      2'd1:    gf_term = gf_dbl(b) ^ b;
      default: gf_term = b;
    endcase
  endfunction
endpackage

// File: rtl/col_pos_track.sv
module col_pos_track
  import mixcol_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             word_start,
  output logic [POS_W-1:0] pos,
  output logic             col_end
);
  logic [POS_W-1:0] idx_q;

  assign pos     = word_start ? '0 : idx_q;
  assign col_end = (pos == POS_W'(COL_N - 1));

  always_ff @(posedge clk) begin
    if (rst)       idx_q <= '0;
    else if (step) idx_q <= pos + 1'b1;
  end

  assert_start_sets_one_R2: assert property (@(posedge clk) disable iff (rst)
    (step && word_start) |=> (idx_q == POS_W'(1)));
  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (!step) |=> $stable(idx_q));
endmodule

// File: rtl/colmix_acc.sv
module colmix_acc
  import mixcol_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [POS_W-1:0]  pos,
  input  logic [BYTE_W-1:0] din,
  output logic [WORD_W-1:0] acc_next
);
  logic [BYTE_W-1:0] acc_q [COL_N];

  for (genvar r = 0; r < COL_N; r++) begin : g_row
    logic [BYTE_W-1:0] base;
    assign base = (pos == '0) ? '0 : acc_q[r];
    assign acc_next[r*BYTE_W +: BYTE_W] = base ^ gf_term(din, pos, r);

    always_ff @(posedge clk) begin
      if (rst)     acc_q[r] <= '0;
      else if (en) acc_q[r] <= acc_next[r*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/init_pack.sv
module init_pack
  import mixcol_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [POS_W-1:0]  pos,
  input  logic [BYTE_W-1:0] din,
  output logic [WORD_W-1:0] packed_word
);
  logic [BYTE_W-1:0] hold_q [COL_N-1];

  for (genvar k = 0; k < COL_N - 1; k++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)                                 hold_q[k] <= '0;
      else if (en && pos == POS_W'(k))         hold_q[k] <= din;
    end
    assign packed_word[k*BYTE_W +: BYTE_W] = hold_q[k];
  end
  assign packed_word[(COL_N-1)*BYTE_W +: BYTE_W] = din;
endmodule

// File: rtl/mixcol_keyadd_stage.sv
module mixcol_keyadd_stage
  import mixcol_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              word_start,
  input  logic [BYTE_W-1:0] key_byte,
  input  logic [WORD_W-1:0] rk_word,
  input  logic              rnd_init,
  input  logic              rnd_mid,
  input  logic              rnd_last,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic [BYTE_W-1:0] ct_byte,
  output logic              ct_valid
);
  logic              sel_init, sel_mid, sel_last, step, col_end;
  logic [POS_W-1:0]  pos;
  logic [BYTE_W-1:0] keyed;
  logic [WORD_W-1:0] mix_word, init_word;

  // R12 priority among round flags
  assign sel_init = rnd_init;
  assign sel_mid  = rnd_mid & ~rnd_init;
  assign sel_last = rnd_last & ~rnd_init & ~rnd_mid;
  assign step     = in_valid & (sel_init | sel_mid | sel_last);
  assign keyed    = in_byte ^ key_byte;

  col_pos_track u_pos (
    .clk(clk), .rst(rst), .step(step), .word_start(word_start),
    .pos(pos), .col_end(col_end)
  );

  colmix_acc u_acc (
    .clk(clk), .rst(rst), .en(in_valid & sel_mid), .pos(pos),
    .din(in_byte), .acc_next(mix_word)
  );

  init_pack u_pack (
    .clk(clk), .rst(rst), .en(in_valid & sel_init), .pos(pos),
    .din(keyed), .packed_word(init_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out   <= '0;
      word_valid <= 1'b0;
      ct_byte    <= '0;
      ct_valid   <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      ct_valid   <= 1'b0;
      if (in_valid && col_end && sel_init) begin
        word_out   <= init_word;
        word_valid <= 1'b1;
      end else if (in_valid && col_end && sel_mid) begin
        word_out   <= mix_word ^ rk_word;
        word_valid <= 1'b1;
      end
      if (in_valid && sel_last) begin
        ct_byte  <= keyed;
        ct_valid <= 1'b1;
      end
    end
  end

  assert_word_after_last_byte_R5: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(in_valid && col_end && (rnd_init || rnd_mid)));
  assert_word_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);
  assert_word_holds_R5: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> $stable(word_out));
  assert_ct_follows_byte_R7: assert property (@(posedge clk) disable iff (rst)
    ct_valid |-> $past(in_valid && rnd_last && !rnd_init && !rnd_mid));
  assert_no_pulse_mix_R7: assert property (@(posedge clk) disable iff (rst)
    !(word_valid && ct_valid));
endmodule

// File: tb/mixcol_keyadd_stage_bench.sv
module mixcol_keyadd_stage_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, word_start = 1'b0;
  logic [7:0]  in_byte = '0, key_byte = '0;
  logic [31:0] rk_word = '0;
  logic        rnd_init = 1'b0, rnd_mid = 1'b0, rnd_last = 1'b0;
  logic [31:0] word_out;
  logic        word_valid;
  logic [7:0]  ct_byte;
  logic        ct_valid;

  int n_checks = 0, n_fail = 0;
  logic [31:0] exp_w[$];
  string       tag_w[$];
  logic [7:0]  exp_c[$];
  logic [31:0] last_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mixcol_keyadd_stage u_mixcol_keyadd_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .word_start(word_start), .key_byte(key_byte), .rk_word(rk_word),
    .rnd_init(rnd_init), .rnd_mid(rnd_mid), .rnd_last(rnd_last),
    .word_out(word_out), .word_valid(word_valid),
    .ct_byte(ct_byte), .ct_valid(ct_valid)
  );

  function automatic logic [7:0] x2(input logic [7:0] b);
    return (b << 1) ^ (b[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [31:0] ref_mix(input logic [7:0] a0, a1, a2, a3);
    logic [7:0] a [4];
    logic [31:0] w;
    a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
    for (int r = 0; r < 4; r++)
      w[r*8 +: 8] = x2(a[r]) ^ x2(a[(r+1)%4]) ^ a[(r+1)%4] ^ a[(r+2)%4] ^ a[(r+3)%4];
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mode: 0 none, 1 opening, 2 regular, 3 closing
  task automatic send(input logic [7:0] b, input logic [7:0] kb, input logic [31:0] rk,
                      input bit st, input int md);
    in_valid = 1'b1; in_byte = b; key_byte = kb; rk_word = rk; word_start = st;
    rnd_init = (md == 1); rnd_mid = (md == 2); rnd_last = (md == 3);
    @(posedge clk); #1;
    in_valid = 1'b0; word_start = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic mid_col(input logic [31:0] col, input logic [31:0] rk, input int gap, input string req);
    exp_w.push_back(ref_mix(col[7:0], col[15:8], col[23:16], col[31:24]) ^ rk);
    tag_w.push_back(req);
    for (int k = 0; k < 4; k++) begin
      send(col[k*8 +: 8], $urandom, (k == 3) ? rk : $urandom, k == 0, 2);
      if (gap > 0 && k < 3) idle(gap);
    end
  endtask

  task automatic init_col(input logic [31:0] pt, input logic [31:0] key);
    exp_w.push_back(pt ^ key);
    tag_w.push_back("R6");
    for (int k = 0; k < 4; k++)
      send(pt[k*8 +: 8], key[k*8 +: 8], $urandom, k == 0, 1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (word_valid) begin
        if (exp_w.size() == 0) check(1'b0, "R5 unexpected word", word_out, 32'h0);
        else begin
          logic [31:0] e; string t;
          e = exp_w.pop_front(); t = tag_w.pop_front();
          check(word_out === e, t, word_out, e);
          last_word = word_out;
        end
      end
      if (ct_valid) begin
        if (exp_c.size() == 0) check(1'b0, "R7 unexpected ct", {24'h0, ct_byte}, 32'h0);
        else begin
          logic [7:0] e;
          e = exp_c.pop_front();
          check(ct_byte === e, "R7", {24'h0, ct_byte}, {24'h0, e});
        end
      end
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    check(1'b0, "watchdog", 32'h0, 32'h0);
    finish_run();
  end

  initial begin
    logic [31:0] c;
    idle(3);
    #1;
    check(word_valid === 1'b0 && ct_valid === 1'b0 && word_out === 32'h0 && ct_byte === 8'h0,
          "R1 reset", {ct_valid, word_valid, ct_byte}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(word_valid === 1'b0 && ct_valid === 1'b0 && word_out === 32'h0, "R1 after reset",
          word_out, 32'h0);
    @(posedge clk); #1;

    // R3: known column, zero key
    mid_col(32'h4553_13DB, 32'h0, 0, "R3");
    idle(2);
    check(last_word === 32'hBCA1_4D8E, "R3 known column", last_word, 32'hBCA1_4D8E);
    // R5: hold after pulse
    idle(3);
    @(negedge clk);
    check(word_out === 32'hBCA1_4D8E && !word_valid, "R5 hold", word_out, 32'hBCA1_4D8E);
    @(posedge clk); #1;

    // R4 random columns with key
    for (int i = 0; i < 40; i++) mid_col($urandom, $urandom, 0, "R4");
    idle(2);
    // R8 gaps
    for (int i = 0; i < 10; i++) mid_col($urandom, $urandom, 1 + i % 3, "R8");
    idle(2);
    // R11 back-to-back, opening column then regular without gap
    for (int i = 0; i < 10; i++) begin
      init_col($urandom, $urandom);
      mid_col($urandom, $urandom, 0, "R11");
    end
    idle(2);

    // R2 wrap without word_start
    c = $urandom;
    exp_w.push_back(ref_mix(c[7:0], c[15:8], c[23:16], c[31:24]) ^ 32'h1234_5678);
    tag_w.push_back("R2 wrap");
    for (int k = 0; k < 4; k++) send(c[k*8 +: 8], 8'h00, 32'h1234_5678, 1'b0, 2);
    idle(2);

    // R9 restart mid column
    send(8'hAA, 8'h0, 32'h0, 1'b1, 2);
    send(8'h55, 8'h0, 32'h0, 1'b0, 2);
    mid_col($urandom, $urandom, 0, "R9");
    idle(2);

    // R10 unflagged byte inside a column, and alone
    c = $urandom;
    exp_w.push_back(ref_mix(c[7:0], c[15:8], c[23:16], c[31:24]) ^ 32'hCAFE_0001);
    tag_w.push_back("R10");
    send(c[7:0], 8'h0, 32'h0, 1'b1, 2);
    send(8'h77, 8'h11, 32'h0, 1'b0, 0);
    send(c[15:8], 8'h0, 32'h0, 1'b0, 2);
    send(c[23:16], 8'h0, 32'h0, 1'b0, 2);
    send(c[31:24], 8'h0, 32'hCAFE_0001, 1'b0, 2);
    idle(2);
    send(8'h99, 8'h22, 32'h0, 1'b1, 0);
    @(negedge clk);
    check(!word_valid && !ct_valid, "R10 no pulse", {ct_valid, word_valid}, 32'h0);
    @(posedge clk); #1;

    // R7 closing round stream, consecutive and with key
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b, k;
      b = $urandom; k = $urandom;
      exp_c.push_back(b ^ k);
      send(b, k, $urandom, i % 4 == 0, 3);
    end
    idle(2);

    // R12 flag priority
    c = $urandom;
    exp_w.push_back(c ^ 32'h0F0F_0F0F);
    tag_w.push_back("R12 init wins");
    for (int k = 0; k < 4; k++) begin
      in_valid = 1'b1; in_byte = c[k*8 +: 8]; key_byte = 8'h0F; rk_word = $urandom;
      word_start = (k == 0); rnd_init = 1'b1; rnd_mid = 1'b1; rnd_last = 1'b1;
      @(posedge clk); #1;
    end
    in_valid = 1'b0; word_start = 1'b0;
    c = $urandom;
    exp_w.push_back(ref_mix(c[7:0], c[15:8], c[23:16], c[31:24]));
    tag_w.push_back("R12 mid wins");
    for (int k = 0; k < 4; k++) begin
      in_valid = 1'b1; in_byte = c[k*8 +: 8]; key_byte = $urandom; rk_word = 32'h0;
      word_start = (k == 0); rnd_init = 1'b0; rnd_mid = 1'b1; rnd_last = 1'b1;
      @(posedge clk); #1;
    end
    in_valid = 1'b0; word_start = 1'b0;
    idle(3);

    check(exp_w.size() == 0, "R5 words missing", exp_w.size(), 0);
    check(exp_c.size() == 0, "R7 bytes missing", exp_c.size(), 0);
    finish_run();
  end
endmodule